// File: doc/BRIEF.md
# Random Generator Control Front End

This block is the register-mapped control and status front end of a true random number generator. Software reaches it over a simple 32-bit register bus with separate read and write strobes. Bringing the generator up takes two steps. Software first sets the activation bit, which stands for powering the analog source. A warm-up counter then runs, and when it has expired a ready flag comes up. Only after that does a write of the digital enable take effect.

While the generator is enabled, the block collects valid bits from a serial raw-bit input. When it has eight of them, it places the byte in a data register and raises a data-valid flag. It can also raise an interrupt for this. The data register can be read once: a read hands out the byte and clears the flag, and a read with no valid byte returns zero. A four-bit clock-range code sets the warm-up length, and software can change it only while the generator is disabled.

Top module: `rng_ctrl_regs`

## Requirements
- R1: The word offsets are control at 0x00, data at 0x04 and activation at 0x0C. A read of 0x08 returns zero, and writes to 0x04 or 0x08 change nothing. Read data is registered: it appears after the clock edge that samples `reg_rd` and holds until the next read.
- R2: Control word layout: bit 0 is enable, bit 1 is data-valid (read-only), bits 5:2 are the range code, bit 6 is the interrupt enable and bit 7 is ready (read-only). Bits 31:8 read as zero. After reset the control word reads 0x00000000.
- R3: The activation word has the activation bit in bit 7. Bits 6:0 always read the version 0x02, and writes to them are ignored.
- R4: A write of 1 to enable takes effect only if activation and ready are both already 1. Otherwise enable stays 0.
- R5: Let L be DELAY_US times the top frequency in MHz of the range code. The codes map to these frequencies: 0→100, 1→80, 2→60, 3→50, 4→40, 5→30, 6→25, 7→20, 8→15, 9→12, 10→9, 11→7, 12→6, and 13, 14 and 15→5. A read sampled on the (L-1)th edge after the activation write shows ready 0. A read sampled on the Lth edge shows ready 1.
- R6: A write that clears activation also clears ready, enable and data-valid on the same edge.
- R7: A control write leaves the range code unchanged while enable is 1. While enable is 0, the write loads the code.
- R8: While enabled, each cycle with `raw_valid` high shifts in `raw_bit`, with the first bit ending up in data bit 7. The eighth bit loads the byte and sets data-valid.
- R9: A data read with data-valid set returns the byte in bits 7:0 and clears data-valid. A data read with data-valid clear returns zero.
- R10: While data-valid is set, raw bits are discarded and leave no residue in the next byte.
- R11: `irq` is high exactly when data-valid and interrupt enable are both 1.
- R12: Clearing enable drops any partly collected byte and clears data-valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| raw_bit | input | 1 | Raw random bit |
| raw_valid | input | 1 | Qualifies raw_bit for one cycle |
| irq | output | 1 | Data-valid interrupt |

## Verification
The properties assume that a strobe addresses one register at a time. They also assume that `raw_valid` only means something while the generator is enabled. Bits the bench drives while the generator is disabled must therefore be ignored. The bench keeps every strobe to a single cycle and uses the defined offsets. It shrinks the warm-up by setting DELAY_US to 1, so both a short code and the longest code can be timed edge by edge.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int OFF_CTL  = 'h0;
  localparam int OFF_DATA = 'h4;
  localparam int OFF_ACT  = 'hC;

  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_DV_BIT  = 1;
  localparam int CTL_RNG_LSB = 2;
  localparam int RNG_W       = 4;
  localparam int CTL_IE_BIT  = 6;
  localparam int CTL_RDY_BIT = 7;
  localparam int ACT_BIT     = 7;
  localparam logic [6:0] VERSION = 7'h02;
  localparam int MAX_MHZ = 100;

  // top frequency of each clock-range code, in MHz
  function automatic int unsigned range_top_mhz(input logic [RNG_W-1:0] code);
    case (code)
      4'd0:    return 100;
      4'd1:    return 80;
      4'd2:    return 60;
      4'd3:    return 50;
      4'd4:    return 40;
      4'd5:    return 30;
      4'd6:    return 25;
      4'd7:    return 20;
      4'd8:    return 15;
      4'd9:    return 12;
      4'd10:   return 9;
      4'd11:   return 7;
      4'd12:   return 6;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/rng_warmup.sv
module rng_warmup
  import rng_pkg::*;
#(
  parameter int DELAY_US = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_next,
  input  logic [RNG_W-1:0] range_code,
  output logic             ready
);
  localparam int MAX_CYC = DELAY_US * MAX_MHZ;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(DELAY_US * range_top_mhz(range_code));

  always_ff @(posedge clk) begin
    if (rst || !act_next) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      if (cnt == limit - CNT_W'(1)) ready <= 1'b1;
      else                          cnt   <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rng_byte_collector.sv
module rng_byte_collector #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              take,
  input  logic              raw_bit,
  input  logic              raw_valid,
  output logic [BYTE_W-1:0] byte_q,
  output logic              valid_q
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [BYTE_W-2:0] shift_q;
  logic [CNT_W-1:0]  nbits;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      nbits   <= '0;
      byte_q  <= '0;
      valid_q <= 1'b0;
    end else if (!run) begin
      nbits   <= '0;
      valid_q <= 1'b0;
    end else if (take) begin
      valid_q <= 1'b0;
    end else if (!valid_q && raw_valid) begin
      if (nbits == CNT_W'(BYTE_W - 1)) begin
        byte_q  <= {shift_q, raw_bit};
        valid_q <= 1'b1;
        nbits   <= '0;
      end else begin
        shift_q <= {shift_q[BYTE_W-3:0], raw_bit};
        nbits   <= nbits + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/rng_ctrl_regs.sv
module rng_ctrl_regs
  import rng_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DELAY_US = 100,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              raw_bit,
  input  logic              raw_valid,
  output logic              irq
);
  logic             act_q, en_q, ie_q;
  logic [RNG_W-1:0] range_q;
  logic             act_d, en_d;
  logic             ready, dv;
  logic [BYTE_W-1:0] byte_q;
  logic             wr_ctl, wr_act, rd_data;
  logic [31:0]      rd_word;
  logic             unused_wbits;

  assign wr_ctl  = reg_wr && (reg_addr == ADDR_W'(OFF_CTL));
  assign wr_act  = reg_wr && (reg_addr == ADDR_W'(OFF_ACT));
  assign rd_data = reg_rd && (reg_addr == ADDR_W'(OFF_DATA)) && dv;
  assign unused_wbits = ^{reg_wdata[31:8], reg_wdata[CTL_DV_BIT]};

  assign act_d = wr_act ? reg_wdata[ACT_BIT] : act_q;

  always_comb begin
    en_d = en_q;
    if (!act_d)      en_d = 1'b0;
    else if (wr_ctl) en_d = reg_wdata[CTL_EN_BIT] && act_q && ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      en_q    <= 1'b0;
      ie_q    <= 1'b0;
      range_q <= '0;
    end else begin
      act_q <= act_d;
      en_q  <= en_d;
      if (wr_ctl) begin
        ie_q <= reg_wdata[CTL_IE_BIT];
        if (!en_q) range_q <= reg_wdata[CTL_RNG_LSB +: RNG_W];
      end
    end
  end

  rng_warmup #(.DELAY_US(DELAY_US)) u_warmup (
    .clk       (clk),
    .rst       (rst),
    .act_next  (act_d),
    .range_code(range_q),
    .ready     (ready)
  );

  rng_byte_collector #(.BYTE_W(BYTE_W)) u_collect (
    .clk      (clk),
    .rst      (rst),
    .run      (en_d),
    .take     (rd_data),
    .raw_bit  (raw_bit),
    .raw_valid(raw_valid),
    .byte_q   (byte_q),
    .valid_q  (dv)
  );

  always_comb begin
    rd_word = '0;
    if (reg_addr == ADDR_W'(OFF_CTL)) begin
      rd_word[CTL_EN_BIT]                 = en_q;
      rd_word[CTL_DV_BIT]                 = dv;
      rd_word[CTL_RNG_LSB +: RNG_W]       = range_q;
      rd_word[CTL_IE_BIT]                 = ie_q;
      rd_word[CTL_RDY_BIT]                = ready;
    end else if (reg_addr == ADDR_W'(OFF_DATA)) begin
      if (dv) rd_word[BYTE_W-1:0] = byte_q;
    end else if (reg_addr == ADDR_W'(OFF_ACT)) begin
      rd_word[6:0]     = VERSION;
      rd_word[ACT_BIT] = act_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_word;
  end

  assign irq = dv && ie_q;
endmodule

// File: rtl/rng_ctrl_chk.sv
module rng_ctrl_chk
  import rng_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              act_q,
  input logic              en_q,
  input logic              ready,
  input logic              dv,
  input logic [RNG_W-1:0]  range_q,
  input logic [BYTE_W-1:0] byte_q
);
  // R4
  en_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
    en_q |-> (act_q && ready));

  // R6
  act_low_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !act_q |-> (!ready && !en_q));

  // R7
  range_locked_chk: assert property (@(posedge clk) disable iff (rst)
    en_q |=> $stable(range_q));

  // R9
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADDR_W'(OFF_DATA) && !dv) |=> (reg_rdata == 32'h0));

  // R12
  idle_no_data_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !dv);

  // R10
  byte_held_chk: assert property (@(posedge clk) disable iff (rst)
    (dv && !(reg_rd && reg_addr == ADDR_W'(OFF_DATA))) |=> $stable(byte_q));
endmodule

bind rng_ctrl_regs rng_ctrl_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_rd   (reg_rd),
  .reg_addr (reg_addr),
  .reg_rdata(reg_rdata),
  .act_q    (act_q),
  .en_q     (en_q),
  .ready    (ready),
  .dv       (dv),
  .range_q  (range_q),
  .byte_q   (byte_q)
);

// File: tb/rng_ctrl_regs_test.sv
`timescale 1ns/1ps
module rng_ctrl_regs_test;
  localparam int ADDR_W = 4;
  localparam logic [3:0] A_CTL = 4'h0, A_DATA = 4'h4, A_RSV = 4'h8, A_ACT = 4'hC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic raw_bit = 1'b0, raw_valid = 1'b0;
  logic irq;

  int checks = 0;
  int fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  rng_ctrl_regs #(.ADDR_W(ADDR_W), .DELAY_US(1), .BYTE_W(8)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .raw_bit(raw_bit),
    .raw_valid(raw_valid), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [31:0] expv, input string tag);
    exp_q.push_back(expv);
    tag_q.push_back(tag);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    raw_valid = 1'b1; raw_bit = b;
    @(negedge clk);
    raw_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  // monitor: compare each completed read against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      if (reg_rd) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R1 unexpected read actual=%h expected=none", reg_rdata);
        end else begin
          check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    bus_read(A_CTL,  32'h0,  "R2 reset control word");
    bus_read(A_ACT,  32'h02, "R3 version after reset");
    bus_read(A_RSV,  32'h0,  "R1 reserved offset");
    bus_read(A_DATA, 32'h0,  "R9 empty data read");
    bus_write(A_CTL, 32'h01);
    bus_read(A_CTL,  32'h0,  "R4 enable refused while inactive");
    bus_write(A_CTL, 32'h34);
    bus_read(A_CTL,  32'h34, "R7 range loads while disabled");
    bus_write(A_DATA, 32'hFF);
    bus_write(A_RSV, 32'hFF);
    bus_read(A_CTL,  32'h34, "R1 writes to data and reserved ignored");

    // R5 code 13 -> L = 5
    bus_write(A_ACT, 32'hFF);
    repeat (3) @(negedge clk);
    bus_read(A_CTL,  32'h34, "R5 ready low at edge L-1");
    bus_read(A_CTL,  32'hB4, "R5 ready high at edge L");
    bus_read(A_ACT,  32'h82, "R3 version bits not writable");

    bus_write(A_CTL, 32'h35);
    bus_read(A_CTL,  32'hB5, "R4 enable accepted");
    bus_write(A_CTL, 32'h01);
    bus_read(A_CTL,  32'hB5, "R7 range held while enabled");

    send_byte(8'hA5);
    bus_read(A_CTL,  32'hB7, "R8 data-valid set");
    bus_read(A_DATA, 32'hA5, "R8 byte order first bit in bit7");
    bus_read(A_DATA, 32'h0,  "R9 second read returns zero");
    bus_read(A_CTL,  32'hB5, "R9 flag cleared by read");

    send_byte(8'h3C);
    send_byte(8'hFF);
    bus_read(A_DATA, 32'h3C, "R10 bits discarded while valid");
    send_byte(8'h0F);
    bus_read(A_DATA, 32'h0F, "R10 no residue from discarded bits");

    bus_write(A_CTL, 32'h75);
    check("R11 irq low without data", {31'b0, irq}, 32'h0);
    send_byte(8'hC3);
    check("R11 irq high with data", {31'b0, irq}, 32'h1);
    bus_read(A_DATA, 32'hC3, "R11 byte read");
    check("R11 irq low after read", {31'b0, irq}, 32'h0);

    // R12 partial byte flush
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    bus_write(A_CTL, 32'h74);
    bus_write(A_CTL, 32'h75);
    send_byte(8'h96);
    bus_read(A_DATA, 32'h96, "R12 partial byte dropped");
    send_byte(8'h5A);
    bus_write(A_CTL, 32'h74);
    bus_read(A_CTL,  32'hF4, "R12 disable clears data-valid");
    bus_read(A_DATA, 32'h0,  "R12 no data after disable");
    send_byte(8'hEE);
    bus_read(A_DATA, 32'h0,  "R12 bits ignored while disabled");

    // R6 deactivation
    bus_write(A_CTL, 32'h75);
    send_byte(8'h11);
    bus_write(A_ACT, 32'h00);
    bus_read(A_CTL,  32'h74, "R6 deactivation clears ready enable valid");
    bus_read(A_ACT,  32'h02, "R6 activation bit low");
    check("R6 irq low after deactivation", {31'b0, irq}, 32'h0);

    // R5 code 0 -> L = 100, with a refused enable during warm-up
    bus_write(A_CTL, 32'h40);
    bus_write(A_ACT, 32'h80);
    bus_write(A_CTL, 32'h41);
    repeat (97) @(negedge clk);
    bus_read(A_CTL,  32'h40, "R4 R5 not ready at edge L-1");
    bus_read(A_CTL,  32'hC0, "R5 ready at edge L for code 0");

    @(negedge clk);
    @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R1 pending reads actual=%0d expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule